// File: doc/BRIEF.md
# Serial Link Power-Mode Sequencer

This block is the digital controller for the clock and power state of one serial link endpoint. It watches a two-bit mode selection and a reference clock. From these it drives three enables: one for the PLL, one for the serial I/O and one for the internal reference bias. It counts reference rising edges during a lock wait and then raises a data-valid qualifier for the parallel port. A free-running sampling clock clocks all of the logic. The reference clock is only sampled, through a synchroniser.

The block has two ways to power down, and they cost different amounts to leave. Mode `00` removes every enable, including the bias, so the next power-up pays the full lock wait. If the reference stops toggling (held high or held low) while the link is powered, the PLL and serial I/O are shut down but the bias stays on. The first reference transition after that starts a shorter re-lock wait. The block also shapes a parallel-clock output: it pulses low briefly when leaving mode `00`, and it follows the serializer-side level once the link is locked. While locked, a bit-clock enable fires `BIT_MULT` (26) times per measured reference period.

Top module: `lnk_pwr_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `pll_en_o`, `sio_en_o`, `bias_en_o`, `data_valid_o` and `bit_ce_o` are 0 and `pclk_o` is 1.
- R2: While `mode_pins` is `00`, all three enables stay 0 and `data_valid_o` stays 0, even with the reference toggling.
- R3: A non-zero `mode_pins` value does not power anything up while the reference is not toggling.
- R4: After a power-up from mode `00`, `pll_en_o`, `sio_en_o` and `bias_en_o` are 1, and `data_valid_o` stays 0 until `FULL_LOCK` reference rising edges have been counted. It then rises.
- R5: If the reference shows no transition for `STALL_LIM` sampling cycles, whether held high or held low, `pll_en_o`, `sio_en_o` and `data_valid_o` go to 0.
- R6: A reference stall never lowers `bias_en_o`. Only mode `00` does.
- R7: The first reference transition after a stall restarts the PLL, and `data_valid_o` returns after `FAST_LOCK` rising edges. `FAST_LOCK` is smaller than `FULL_LOCK`.
- R8: Mode `00` overrides every state. The mode pins pass through two synchroniser stages and one state register, so the enables are still on at the second sampling edge after the pins change and are all 0 at the third.
- R9: On leaving mode `00`, `pclk_o` is 0 for exactly `PCLK_LOW` sampling cycles. It is then 1 until `data_valid_o` rises, and after that it equals `ser_level_in`.
- R10: While `data_valid_o` is 1 and the reference period is steady, `bit_ce_o` pulses exactly `BIT_MULT` times in every reference period. It never pulses while `data_valid_o` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_pins | input | 2 | Mode selection; `00` is power-down, any other value requests power |
| ref_clk_in | input | 1 | Reference clock, sampled asynchronously |
| ser_level_in | input | 1 | Serializer-side parallel clock level |
| pll_en_o | output | 1 | PLL enable |
| sio_en_o | output | 1 | Serial I/O enable |
| bias_en_o | output | 1 | Internal reference-bias enable |
| data_valid_o | output | 1 | Lock complete, parallel data may be captured |
| bit_ce_o | output | 1 | Bit-clock enable, BIT_MULT pulses per reference period |
| pclk_o | output | 1 | Parallel-clock qualifier output |

## Verification
A state register stuck in, or wrongly moved to, the stalled state shows within one sampling cycle as `pll_en_o` low with `bias_en_o` high. The bench catches this by checking all enables after every stall and resume. A miscounted lock wait moves the rise of `data_valid_o` by a whole reference period, which the checks one period before and one period after the nominal count detect. A wrong bit-enable accumulator breaks the 26-per-period count over a three-period window, and a mode-path error breaks the exact second-versus-third edge check of the override.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_LOCK_FULL = 3'd1,
    ST_LOCK_FAST = 3'd2,
    ST_ACTIVE    = 3'd3,
    ST_STALLED   = 3'd4
  } lps_state_e;

endpackage

// File: rtl/lps_ref_mon.sv
// Synchronises the reference, detects edges and flags a stalled reference.
module lps_ref_mon #(
  parameter int STALL_LIM = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise_o,
  output logic edge_o,
  output logic stalled_o
);

  localparam int CW = $clog2(STALL_LIM + 1);

  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] idle_q, idle_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ref_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q ^ s3_q;
  assign rise_o = s2_q & ~s3_q;

  always_comb begin
    idle_d = idle_q;
    if (edge_o)
      idle_d = '0;
    else if (idle_q != CW'(STALL_LIM))
      idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= CW'(STALL_LIM);
    else        idle_q <= idle_d;
  end

  assign stalled_o = (idle_q == CW'(STALL_LIM));

  AST_EDGE_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !stalled_o); // R5

endmodule

// File: rtl/lps_lock_tmr.sv
// Counts reference rising edges during a lock wait, saturating.
module lps_lock_tmr #(
  parameter int LIMIT = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           inc,
  output logic [$clog2(LIMIT+1)-1:0]     cnt_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (inc && cnt_q != CW'(LIMIT))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/lps_bitce_gen.sv
// Measures the reference period and spreads MULT enable pulses over it.
module lps_bitce_gen #(
  parameter int MULT  = 26,
  parameter int PER_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic run,
  output logic ce_o
);

  localparam int AW = PER_W + $clog2(MULT + 1);
  localparam logic [PER_W-1:0] PC_MAX = '1;

  logic [PER_W-1:0] pc_q, pc_d, per_q, per_d;
  logic [AW-1:0]    acc_q, acc_d, sum;
  logic             hit;

  always_comb begin
    pc_d  = pc_q;
    per_d = per_q;
    if (rise) begin
      pc_d  = '0;
      per_d = (pc_q == PC_MAX) ? PC_MAX : pc_q + 1'b1;
    end else if (pc_q != PC_MAX) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_comb begin
    sum = (rise ? '0 : acc_q) + AW'(MULT);
    hit = (per_q != '0) && (sum >= AW'(per_q));
    if (per_q == '0)
      acc_d = '0;
    else if (hit)
      acc_d = sum - AW'(per_q);
    else
      acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      per_q <= '0;
      acc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      per_q <= per_d;
      acc_q <= acc_d;
    end
  end

  assign ce_o = run & hit;

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_q >= PER_W'(MULT)) |-> (acc_q < AW'(per_q))); // R10

endmodule

// File: rtl/lnk_pwr_seq.sv
module lnk_pwr_seq
  import lps_pkg::*;
#(
  parameter int FULL_LOCK = 8,
  parameter int FAST_LOCK = 3,
  parameter int STALL_LIM = 100,
  parameter int PCLK_LOW  = 4,
  parameter int BIT_MULT  = 26,
  parameter int PER_W     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_pins,
  input  logic       ref_clk_in,
  input  logic       ser_level_in,
  output logic       pll_en_o,
  output logic       sio_en_o,
  output logic       bias_en_o,
  output logic       data_valid_o,
  output logic       bit_ce_o,
  output logic       pclk_o
);

  localparam int LCW = $clog2(FULL_LOCK + 1);
  localparam int PW  = $clog2(PCLK_LOW + 1);

  logic           rs1_q, rst_s_n;
  logic [1:0]     m1_q, m2_q;
  logic           rise, ref_edge, stalled;
  logic           lock_clr;
  logic [LCW-1:0] lock_cnt;
  logic           lock_done;
  logic [PW-1:0]  pl_q, pl_d;
  lps_state_e     state_q, state_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_s_n <= rs1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      m1_q <= 2'b00;
      m2_q <= 2'b00;
    end else begin
      m1_q <= mode_pins;
      m2_q <= m1_q;
    end
  end

  lps_ref_mon #(.STALL_LIM(STALL_LIM)) u_ref_mon (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .ref_in   (ref_clk_in),
    .rise_o   (rise),
    .edge_o   (ref_edge),
    .stalled_o(stalled)
  );

  lps_lock_tmr #(.LIMIT(FULL_LOCK)) u_lock_tmr (
    .clk  (clk),
    .rst_n(rst_s_n),
    .clr  (lock_clr),
    .inc  (rise),
    .cnt_o(lock_cnt)
  );

  always_comb begin
    lock_done = 1'b0;
    if (state_q == ST_LOCK_FULL) lock_done = (lock_cnt >= LCW'(FULL_LOCK));
    if (state_q == ST_LOCK_FAST) lock_done = (lock_cnt >= LCW'(FAST_LOCK));
  end

  always_comb begin
    state_d = state_q;
    if (m2_q == 2'b00) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:       if (!stalled) state_d = ST_LOCK_FULL;
        ST_LOCK_FULL,
        ST_LOCK_FAST: if (stalled) state_d = ST_STALLED;
                      else if (lock_done) state_d = ST_ACTIVE;
        ST_ACTIVE:    if (stalled) state_d = ST_STALLED;
        ST_STALLED:   if (!stalled) state_d = ST_LOCK_FAST;
        default:      state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= ST_OFF;
    else          state_q <= state_d;
  end

  assign lock_clr = (state_d != state_q) &&
                    (state_d == ST_LOCK_FULL || state_d == ST_LOCK_FAST);

  // low pulse on the parallel clock when leaving power-down
  always_comb begin
    pl_d = pl_q;
    if (state_q == ST_OFF && state_d == ST_LOCK_FULL)
      pl_d = PW'(PCLK_LOW);
    else if (pl_q != '0)
      pl_d = pl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) pl_q <= '0;
    else          pl_q <= pl_d;
  end

  assign pll_en_o     = (state_q == ST_LOCK_FULL) || (state_q == ST_LOCK_FAST) ||
                        (state_q == ST_ACTIVE);
  assign sio_en_o     = pll_en_o;
  assign bias_en_o    = (state_q != ST_OFF);
  assign data_valid_o = (state_q == ST_ACTIVE);
  assign pclk_o       = (pl_q != '0) ? 1'b0 : (data_valid_o ? ser_level_in : 1'b1);

  lps_bitce_gen #(.MULT(BIT_MULT), .PER_W(PER_W)) u_bitce (
    .clk  (clk),
    .rst_n(rst_s_n),
    .rise (rise),
    .run  (data_valid_o),
    .ce_o (bit_ce_o)
  );

  AST_MODE0_DROPS_BIAS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (m2_q == 2'b00) |=> !bias_en_o); // R8
  AST_BIAS_ONLY_MODE0: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(bias_en_o) |-> ($past(m2_q) == 2'b00)); // R6
  AST_VALID_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(data_valid_o) |-> $past(pll_en_o)); // R4
  AST_STALL_STOPS_PLL: assert property (@(posedge clk) disable iff (!rst_s_n)
    stalled |=> !pll_en_o); // R5
  AST_CE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_ce_o |-> pll_en_o); // R10

endmodule

// File: tb/test_lnk_pwr_seq.sv
`timescale 1ns/1ps
module test_lnk_pwr_seq;

  localparam int FULL  = 8;
  localparam int FAST  = 3;
  localparam int STALL = 100;
  localparam int PLOW  = 4;
  localparam int MULT  = 26;
  localparam int HALF  = 30;
  localparam int P     = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       ref_clk;
  logic       ser;
  logic       pll, sio, bias, dv, bce, pclk;
  logic       ref_run;
  int         ref_ctr;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  lnk_pwr_seq #(
    .FULL_LOCK(FULL), .FAST_LOCK(FAST), .STALL_LIM(STALL),
    .PCLK_LOW(PLOW), .BIT_MULT(MULT), .PER_W(10)
  ) i_lnk_pwr_seq (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode), .ref_clk_in(ref_clk),
    .ser_level_in(ser), .pll_en_o(pll), .sio_en_o(sio), .bias_en_o(bias),
    .data_valid_o(dv), .bit_ce_o(bce), .pclk_o(pclk)
  );

  always @(negedge clk) begin
    if (ref_run) begin
      if (ref_ctr == HALF - 1) begin
        ref_clk <= ~ref_clk;
        ref_ctr <= 0;
      end else begin
        ref_ctr <= ref_ctr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(pll == 0 && sio == 0 && bias == 0, "R1 enables after reset", {pll, sio, bias}, 0);
    chk(dv == 0 && bce == 0, "R1 valid/ce after reset", {dv, bce}, 0);
    chk(pclk == 1, "R1 pclk after reset", pclk, 1);
  endtask

  task automatic t_no_ref;
    mode = 2'b11;
    wait_cyc(200);
    chk(pll == 0 && bias == 0, "R3 no power-up on stopped reference", {pll, bias}, 0);
    mode = 2'b00;
    wait_cyc(5);
  endtask

  task automatic t_mode0_idle;
    ref_run = 1'b1;
    wait_cyc(300);
    chk(pll == 0 && sio == 0 && bias == 0, "R2 mode 00 keeps enables off", {pll, sio, bias}, 0);
    chk(dv == 0, "R2 mode 00 keeps valid low", dv, 0);
  endtask

  task automatic t_full_lock(input logic [1:0] m);
    int lows = 0;
    int ce_lock = 0;
    ser = 1'b0;
    mode = m;
    for (int c = 1; c <= (FULL + 1) * P + 10; c++) begin
      @(negedge clk);
      if (c <= 20 && !pclk) lows++;
      if (!dv && bce) ce_lock++;
      if (c == 30) chk(pclk == 1, "R9 pclk high while locking", pclk, 1);
      if (c == (FULL - 1) * P) begin
        chk(dv == 0, "R4 valid low before full count", dv, 0);
        chk(pll && sio && bias, "R4 enables on during lock", {pll, sio, bias}, 7);
      end
    end
    chk(lows == PLOW, "R9 pclk low pulse length", lows, PLOW);
    chk(dv == 1, "R4 valid after full count", dv, 1);
    chk(ce_lock == 0, "R10 no bit enable while locking", ce_lock, 0);
  endtask

  task automatic t_active;
    int n = 0;
    wait_cyc(3 * P);
    for (int c = 0; c < 3 * P; c++) begin
      @(negedge clk);
      if (bce) n++;
    end
    chk(n == 3 * MULT, "R10 bit enables per three periods", n, 3 * MULT);
    ser = 1'b1;
    @(negedge clk);
    chk(pclk == 1, "R9 pclk follows level 1", pclk, 1);
    ser = 1'b0;
    @(negedge clk);
    chk(pclk == 0, "R9 pclk follows level 0", pclk, 0);
  endtask

  task automatic t_stop(input logic lvl);
    int n = 0;
    while (ref_clk !== lvl) @(negedge clk);
    ref_run = 1'b0;
    wait_cyc(STALL + 50);
    chk(pll == 0 && sio == 0 && dv == 0, "R5 stall shuts PLL and I/O", {pll, sio, dv}, 0);
    chk(bias == 1, "R6 bias kept during stall", bias, 1);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (bce) n++;
    end
    chk(n == 0, "R10 no bit enable while stalled", n, 0);
  endtask

  task automatic t_resume;
    int drops = 0;
    ref_run = 1'b1;
    @(ref_clk);
    for (int c = 1; c <= (FAST + 1) * P + 10; c++) begin
      @(negedge clk);
      if (!bias) drops++;
      if (c == (FAST - 1) * P) chk(dv == 0, "R7 valid low before fast count", dv, 0);
    end
    chk(dv == 1, "R7 valid after fast count", dv, 1);
    chk(drops == 0, "R6 bias held through re-lock", drops, 0);
  endtask

  task automatic t_override;
    mode = 2'b00;
    @(negedge clk);
    @(negedge clk);
    chk(bias == 1, "R8 bias still on at second edge", bias, 1);
    @(negedge clk);
    chk(bias == 0 && pll == 0 && sio == 0, "R8 mode 00 forces off at third edge",
        {bias, pll, sio}, 0);
    wait_cyc(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    mode    = 2'b00;
    ref_clk = 1'b0;
    ref_run = 1'b0;
    ref_ctr = 0;
    ser     = 1'b0;
    wait_cyc(2);
    t_reset();
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_no_ref();
    t_mode0_idle();
    t_full_lock(2'b01);
    t_active();
    t_stop(1'b1);
    t_resume();
    t_active();
    t_stop(1'b0);
    t_resume();
    t_override();
    t_full_lock(2'b10);
    t_stop(1'b1);
    t_override();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule